// File: doc/BRIEF.md
# Cascade DMA Bus-Master Sequencer

This block lets a peripheral take over a 16-bit ISA-style system bus through a DMA channel in cascade mode, and then run memory read and write cycles on it. When the internal side presents a transfer request, the block raises its bus request and waits for the acknowledge. An acknowledge that comes while a memory refresh is in progress is not accepted, and the block goes on waiting. When it has a valid acknowledge, the block raises a master indication toward the permanent master. It then drives the address, the byte-high enable and one of the two active-low memory strobes, and it moves the data word.

Transfers use a request/done handshake. The requester holds `req_valid` and the request fields steady until it sees a one-cycle `req_done`, which also returns the read data. If another request is waiting when a cycle ends, the block keeps the bus and runs it. If none is waiting, the block gives the bus back: the request and the master indication drop and every bus driver is released. Tristate buses are shown as a value and an output enable.

The state machine has seven states:
- IDLE: the bus is released.
- REQ: the bus request is raised and the block waits for the acknowledge.
- OWN: the block owns the bus and takes in the next request.
- SETUP: the address is driven with both strobes inactive.
- STROBE: one strobe is low for a fixed count of clocks.
- FINISH: the strobe is inactive and the done pulse is given.
- RELEASE: the request and master lines drop for one cycle.

The transitions are:
- IDLE to REQ when a request is pending.
- REQ to OWN when the acknowledge is high and refresh is low.
- OWN to SETUP when a request is pending, and OWN to RELEASE when none is.
- SETUP to STROBE.
- STROBE to FINISH after the last strobe clock.
- FINISH to OWN.
- RELEASE to IDLE.

Top module: `isa_dma_master`

## Requirements
- R1: When `rst` (active high, synchronous) is asserted, all of the following hold after the next clock edge: `drq`, `master`, `addr_oe`, `cmd_oe`, `sd_oe` and `req_done` are 0, and `memr_n` and `memw_n` are 1.
- R2: If `req_valid` is high in IDLE, `drq` is high from the next cycle on. It stays high for as long as the block is waiting for the acknowledge or owns the bus.
- R3: If `dack` is high while `ref_act` is high, the acknowledge is ignored: `master` stays 0 and `drq` stays 1.
- R4: If `dack` is high and `ref_act` is low while the block is waiting, `master` is 1 from the next cycle on.
- R5: In a write cycle (`req_write`=1), `memw_n` is low for exactly STROBE_CYC (3) consecutive clocks. `memr_n` stays high. `sd_oe`=1 and `sd_o` equals the write data throughout the cycle.
- R6: In a read cycle (`req_write`=0), `memr_n` is low for exactly STROBE_CYC clocks and `sd_oe` stays 0. `req_rdata` returns the `sd_i` value sampled on the last low-strobe clock.
- R7: While `addr_oe`=1, `sa` equals address bits 19:0 and `la` equals address bits 23:17, so `sa[19:17]` equals `la[2:0]`. `sbhe_n` is the inverse of `req_bhe`.
- R8: `req_done` is a single-cycle pulse. It is raised once per transfer, on the cycle just after the strobe returns high.
- R9: If a request is pending when a cycle finishes, the next cycle runs without `drq` or `master` dropping.
- R10: If no request is pending when a cycle finishes, `drq` and `master` drop two cycles after `req_done`, and `addr_oe`, `cmd_oe` and `sd_oe` all go to 0.
- R11: `memr_n` and `memw_n` are never low at the same time. No strobe is low unless `master` and `cmd_oe` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request pending |
| req_addr | input | 24 | Transfer byte address |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_bhe | input | 1 | Enable the high data byte |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-cycle transfer completion |
| req_rdata | output | 16 | Read data, valid with req_done |
| drq | output | 1 | DMA bus request |
| dack | input | 1 | DMA acknowledge |
| ref_act | input | 1 | Memory refresh in progress |
| master | output | 1 | Current-master indication |
| sa | output | 20 | Latched system address value |
| la | output | 7 | Unlatched upper address value (bits 23:17) |
| addr_oe | output | 1 | Drive enable for sa, la and sbhe_n |
| sbhe_n | output | 1 | Byte-high enable, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| cmd_oe | output | 1 | Drive enable for the strobes |
| sd_o | output | 16 | Data bus output value |
| sd_i | input | 16 | Data bus input value |
| sd_oe | output | 1 | Data bus drive enable |

## Verification
The bench sweeps sessions of one to three back-to-back transfers. Each session mixes reads and writes, both byte-high settings and computed addresses that set every upper bit at some point, so an address or direction decoded wrongly shows up as a mismatch on the address, strobe or data pins. Each session holds the acknowledge during zero to two refresh cycles before granting. This separates a refresh mask that works from one that lets an acknowledge through early. It also separates sessions that keep the bus between transfers from sessions that release it after the last one. Strobe length and read sampling are checked cycle by cycle against the fixed count of three.

// File: rtl/isa_dma_pkg.sv
package isa_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_OWN,
        ST_SETUP,
        ST_STROBE,
        ST_FINISH,
        ST_RELEASE
    } dma_state_t;

    typedef struct packed {
        logic drq;
        logic master;
        logic bus_oe;
        logic strobe;
        logic capture;
        logic sample;
        logic done;
    } dma_ctl_t;

endpackage

// File: rtl/isa_dma_fsm.sv
module isa_dma_fsm
    import isa_dma_pkg::*;
#(
    parameter int STROBE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       dack,
    input  logic       ref_act,
    output dma_ctl_t   ctl
);
    localparam int CW = $clog2(STROBE_CYC + 1);

    dma_state_t      state, state_nx;
    logic [CW-1:0]   cnt;
    logic            cnt_last;

    assign cnt_last = (cnt == CW'(STROBE_CYC - 1));

    // state register and strobe counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_STROBE && !cnt_last)
                cnt <= cnt + CW'(1);
            else
                cnt <= '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid)        state_nx = ST_REQ;
            ST_REQ:     if (dack && !ref_act) state_nx = ST_OWN;   // refresh masks the acknowledge
            ST_OWN:     state_nx = req_valid ? ST_SETUP : ST_RELEASE;
            ST_SETUP:   state_nx = ST_STROBE;
            ST_STROBE:  if (cnt_last)         state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_OWN;
            ST_RELEASE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE:    ;
            ST_REQ:     ctl.drq = 1'b1;
            ST_OWN: begin
                ctl.drq     = 1'b1;
                ctl.master  = 1'b1;
                ctl.capture = req_valid;
            end
            ST_SETUP: begin
                ctl.drq    = 1'b1;
                ctl.master = 1'b1;
                ctl.bus_oe = 1'b1;
            end
            ST_STROBE: begin
                ctl.drq    = 1'b1;
                ctl.master = 1'b1;
                ctl.bus_oe = 1'b1;
                ctl.strobe = 1'b1;
                ctl.sample = cnt_last;
            end
            ST_FINISH: begin
                ctl.drq    = 1'b1;
                ctl.master = 1'b1;
                ctl.bus_oe = 1'b1;
                ctl.done   = 1'b1;
            end
            ST_RELEASE: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/isa_dma_bus.sv
module isa_dma_bus #(
    parameter int ADDR_W = 24,
    parameter int SA_W   = 20,
    parameter int LA_LO  = 17,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    capture,
    input  logic                    sample,
    input  logic                    bus_oe,
    input  logic                    strobe,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_bhe,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W-1:0]       sd_i,
    output logic [SA_W-1:0]         sa,
    output logic [ADDR_W-LA_LO-1:0] la,
    output logic                    sbhe_n,
    output logic                    memr_n,
    output logic                    memw_n,
    output logic [DATA_W-1:0]       sd_o,
    output logic                    sd_oe,
    output logic [DATA_W-1:0]       rdata
);
    logic [ADDR_W-1:0] addr_r;
    logic              wr_r, bhe_r;
    logic [DATA_W-1:0] wd_r, rd_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r <= '0;
            wr_r   <= 1'b0;
            bhe_r  <= 1'b0;
            wd_r   <= '0;
            rd_r   <= '0;
        end else begin
            if (capture) begin
                addr_r <= req_addr;
                wr_r   <= req_write;
                bhe_r  <= req_bhe;
                wd_r   <= req_wdata;
            end
            if (sample && !wr_r)
                rd_r <= sd_i;
        end
    end

    // the upper latched bits and the unlatched bits share one register
    assign sa     = addr_r[SA_W-1:0];
    assign la     = addr_r[ADDR_W-1:LA_LO];
    assign sbhe_n = ~bhe_r;
    assign memr_n = ~(strobe && !wr_r);
    assign memw_n = ~(strobe && wr_r);
    assign sd_o   = wd_r;
    assign sd_oe  = bus_oe && wr_r;
    assign rdata  = rd_r;

endmodule

// File: rtl/isa_dma_master.sv
module isa_dma_master
    import isa_dma_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SA_W       = 20,
    parameter int LA_LO      = 17,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_bhe,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_done,
    output logic [DATA_W-1:0]       req_rdata,
    output logic                    drq,
    input  logic                    dack,
    input  logic                    ref_act,
    output logic                    master,
    output logic [SA_W-1:0]         sa,
    output logic [ADDR_W-LA_LO-1:0] la,
    output logic                    addr_oe,
    output logic                    sbhe_n,
    output logic                    memr_n,
    output logic                    memw_n,
    output logic                    cmd_oe,
    output logic [DATA_W-1:0]       sd_o,
    input  logic [DATA_W-1:0]       sd_i,
    output logic                    sd_oe
);
    dma_ctl_t ctl;

    isa_dma_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .dack      (dack),
        .ref_act   (ref_act),
        .ctl       (ctl)
    );

    isa_dma_bus #(
        .ADDR_W (ADDR_W),
        .SA_W   (SA_W),
        .LA_LO  (LA_LO),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .capture   (ctl.capture),
        .sample    (ctl.sample),
        .bus_oe    (ctl.bus_oe),
        .strobe    (ctl.strobe),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_bhe   (req_bhe),
        .req_wdata (req_wdata),
        .sd_i      (sd_i),
        .sa        (sa),
        .la        (la),
        .sbhe_n    (sbhe_n),
        .memr_n    (memr_n),
        .memw_n    (memw_n),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe),
        .rdata     (req_rdata)
    );

    assign drq      = ctl.drq;
    assign master   = ctl.master;
    assign addr_oe  = ctl.bus_oe;
    assign cmd_oe   = ctl.bus_oe;
    assign req_done = ctl.done;

endmodule

// File: rtl/isa_dma_master_chk.sv
module isa_dma_master_chk #(
    parameter int STROBE_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic drq,
    input logic dack,
    input logic ref_act,
    input logic master,
    input logic memr_n,
    input logic memw_n,
    input logic cmd_oe,
    input logic req_done
);
    localparam int LW = $clog2(STROBE_CYC + 2);

    logic          strb_low;
    logic [LW-1:0] low_cnt;

    assign strb_low = !memr_n || !memw_n;

    always_ff @(posedge clk) begin
        if (rst)           low_cnt <= '0;
        else if (strb_low) low_cnt <= low_cnt + LW'(1);
        else               low_cnt <= '0;
    end

    assert_refresh_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (drq && !master && dack && ref_act) |=> !master);

    assert_grant_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(master) |-> $past(dack && !ref_act));

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
        (!strb_low && $past(strb_low)) |-> (low_cnt == LW'(STROBE_CYC)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !(!memr_n && !memw_n));

    assert_strobe_owned_R11: assert property (@(posedge clk) disable iff (rst)
        strb_low |-> (master && cmd_oe));

    assert_master_has_drq_R10: assert property (@(posedge clk) disable iff (rst)
        master |-> drq);

endmodule

bind isa_dma_master isa_dma_master_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .drq      (drq),
    .dack     (dack),
    .ref_act  (ref_act),
    .master   (master),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .cmd_oe   (cmd_oe),
    .req_done (req_done)
);

// File: tb/isa_dma_master_tb.sv
module isa_dma_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_bhe = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_done;
    logic [15:0] req_rdata;
    logic        drq;
    logic        dack = 1'b0;
    logic        ref_act = 1'b0;
    logic        master;
    logic [19:0] sa;
    logic [6:0]  la;
    logic        addr_oe, sbhe_n, memr_n, memw_n, cmd_oe, sd_oe;
    logic [15:0] sd_o;
    logic [15:0] sd_i = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    isa_dma_master u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_bhe(req_bhe), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata), .drq(drq), .dack(dack),
        .ref_act(ref_act), .master(master), .sa(sa), .la(la), .addr_oe(addr_oe),
        .sbhe_n(sbhe_n), .memr_n(memr_n), .memw_n(memw_n), .cmd_oe(cmd_oe),
        .sd_o(sd_o), .sd_i(sd_i), .sd_oe(sd_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        chk(!(!memr_n && !memw_n), "R11", "both strobes low", {memr_n, memw_n}, 2'b11);
    endtask

    task automatic chk_released(input string req);
        chk(drq == 0 && master == 0, req, "drq/master", {drq, master}, 0);
        chk(addr_oe == 0 && cmd_oe == 0 && sd_oe == 0, req, "output enables",
            {addr_oe, cmd_oe, sd_oe}, 0);
        chk(memr_n && memw_n && !req_done, req, "strobes/done", {memr_n, memw_n, req_done}, 3'b110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_released("R1");
        rst = 1'b0;
        step();
        chk_released("R1");

        for (int s = 0; s < 12; s++) begin
            int ntx  = s % 3 + 1;
            int refc = (s / 3) % 3;
            // first request
            req_valid = 1'b1;
            step();
            chk(drq == 1 && master == 0, "R2", "request raised", {drq, master}, 2'b10);
            for (int k = 0; k < refc; k++) begin
                dack = 1'b1; ref_act = 1'b1;
                step();
                chk(drq == 1 && master == 0, "R3", "ack during refresh", {drq, master}, 2'b10);
            end
            dack = 1'b0; ref_act = 1'b0;
            step();
            chk(drq == 1 && master == 0, "R2", "waiting without ack", {drq, master}, 2'b10);
            dack = 1'b1;
            for (int t = 0; t < ntx; t++) begin
                logic        wr  = 1'((s + t) & 1);
                logic        bhe = 1'(((s >> 1) ^ t) & 1);
                logic [23:0] a   = 24'((s * 7 + t * 3 + 1) * 24'h2B4C97);
                logic [15:0] wd  = 16'((s * 97 + t * 31) * 16'h1357 + 16'h0A5);
                logic [15:0] rd  = 16'((s * 53 + t * 17) * 16'h2468 + 16'h5C3);
                req_addr = a; req_write = wr; req_bhe = bhe; req_wdata = wd;
                if (t == 0) begin
                    step();   // OWN
                    chk(master == 1, "R4", "master after valid ack", master, 1);
                end
                chk(drq == 1 && master == 1, "R9", "bus held in OWN", {drq, master}, 2'b11);
                step();   // SETUP
                sd_i = rd;
                chk(addr_oe && sa == a[19:0] && la == a[23:17], "R7", "address",
                    {4'h0, la, sa}, {4'h0, a[23:17], a[19:0]});
                chk(sa[19:17] == la[2:0], "R7", "latched/unlatched overlap", sa[19:17], la[2:0]);
                chk(sbhe_n == !bhe, "R7", "byte high enable", sbhe_n, !bhe);
                chk(memr_n && memw_n && cmd_oe, "R5", "setup strobes idle", {memr_n, memw_n}, 2'b11);
                for (int c = 0; c < 3; c++) begin
                    step();   // STROBE
                    if (wr) begin
                        chk(!memw_n && memr_n, "R5", "write strobe", {memr_n, memw_n}, 2'b10);
                        chk(sd_oe && sd_o == wd, "R5", "write data", sd_o, wd);
                    end else begin
                        chk(!memr_n && memw_n, "R6", "read strobe", {memr_n, memw_n}, 2'b01);
                        chk(!sd_oe, "R6", "data not driven on read", sd_oe, 0);
                    end
                end
                step();   // FINISH
                chk(memr_n && memw_n, "R5", "strobe ends after 3", {memr_n, memw_n}, 2'b11);
                chk(req_done == 1, "R8", "done pulse", req_done, 1);
                if (!wr) chk(req_rdata == rd, "R6", "read data", req_rdata, rd);
                if (t == ntx - 1) req_valid = 1'b0;
                step();   // OWN
                chk(req_done == 0, "R8", "done single cycle", req_done, 0);
            end
            step();   // RELEASE
            chk_released("R10");
            dack = 1'b0;
            step();   // IDLE
            chk_released("R10");
        end

        // reset in the middle of a session
        req_valid = 1'b1;
        dack = 1'b1;
        repeat (4) step();
        rst = 1'b1;
        req_valid = 1'b0;
        step();
        chk_released("R1");
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule